// File: doc/BRIEF.md
# SEC-DED ECC Check and Log Unit

This block sits on the read return path of a 64-bit memory controller. Each returned word arrives with eight stored check bits. The block forms an 8-bit syndrome from the word and its check bits, and classes the result in one of four ways:

- clean;
- a single flipped data bit, which can be repaired;
- a single flipped check bit, which leaves the data intact;
- an uncorrectable error covering more than one bit.

One clock later it returns the word. The data is repaired when correction is enabled. When the error is uncorrectable, the word is replaced by an abort response.

Accesses that belong to already-acknowledged (posted) writes never abort. Their uncorrectable errors show up only as a status bit and the interrupt. When reporting is enabled, detected errors set sticky status bits, which software clears by writing one. Detected errors also raise an interrupt. They latch the failing address and syndrome into log registers that keep the first error. A separate combinational generator produces check bits for write data, with an option that treats the upper half of the word as zero for 32-bit accesses.

Top module: `ecc_check_unit`

## Requirements
- R1: Column i of the parity-check matrix (data bit i) is built as follows. Column 0 is 8'hC1. For every other data bit, let its class be the value of bit i of 64'h4DFF0F00_E2111111. Collect the 8-bit codes that have odd weight of at least 3, excluding 8'hC1, in ascending order. Data bit i takes the next unused code from that list whose bit 0 equals its class. Syndrome bit r is the XOR of rd_check[r] with all data bits whose column has bit r set. The syndrome is visible on log_syn when it is captured.
- R2: With a zero syndrome, out_data equals rd_data and out_sbe, out_mbe and out_abort are all low.
- R3: When the syndrome equals a data column and corr_en is high, out_data is rd_data with that bit inverted, and out_sbe is high.
- R4: With corr_en low, a single data-bit error returns rd_data unchanged but still raises out_sbe.
- R5: A syndrome of weight one, which marks a check-bit error, returns rd_data unchanged with out_sbe high.
- R6: Any other nonzero syndrome raises out_mbe. For a non-posted access it also raises out_abort and drives out_data to zero.
- R7: On a posted access (rd_posted high), an uncorrectable error does not abort and returns the raw data. With reporting enabled it sets only sts[2] and leaves the logs unchanged.
- R8: The outputs are registered. out_valid follows rd_valid with a latency of exactly one clock, and reset clears out_valid, sts and the logs.
- R9: With rpt_en high, a single-bit error sets sts[0] and a non-posted uncorrectable error sets sts[1]. The status bits are sticky and irq is high while any sts bit is set. The address and syndrome are logged only while sts[1:0] is zero, so the first error is kept.
- R10: Writing 1 to a bit of sts_clr clears that sts bit on the next edge. A new error that sets the same bit in the same cycle wins over the clear.
- R11: With rpt_en low, no error changes sts, log_addr or log_syn.
- R12: wr_check is the check-bit vector of wr_data under the R1 matrix. When wr_narrow is high, wr_data[63:32] is taken as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| corr_en | input | 1 | Enable single-bit data correction |
| rpt_en | input | 1 | Enable status, logging and interrupt |
| wr_data | input | 64 | Write data for check-bit generation |
| wr_narrow | input | 1 | Treat wr_data as 32-bit (upper half zero) |
| wr_check | output | 8 | Generated check bits for wr_data |
| rd_valid | input | 1 | Read word present this cycle |
| rd_posted | input | 1 | Read belongs to an already-acknowledged write |
| rd_addr | input | ADDR_W | Address of the read |
| rd_data | input | 64 | Data read from memory |
| rd_check | input | 8 | Check bits read from memory |
| out_valid | output | 1 | Returned word valid |
| out_data | output | 64 | Returned (possibly corrected) data |
| out_abort | output | 1 | Access completes with an error response |
| out_sbe | output | 1 | Single-bit error seen on this word |
| out_mbe | output | 1 | Uncorrectable error seen on this word |
| sts_clr | input | 3 | Write-one-to-clear strobes for sts |
| sts | output | 3 | Sticky status: [0] single, [1] multi, [2] posted multi |
| irq | output | 1 | Interrupt, high while any sts bit is set |
| log_addr | output | ADDR_W | Address of the logged error |
| log_syn | output | 8 | Syndrome of the logged error |

## Verification
The assertions check on every cycle the properties that need only port values over time:

- the one-clock valid latency;
- abort only together with an uncorrectable flag, and never on posted accesses;
- clean or uncorrected words passing through bit-exact;
- sticky status that falls only after a clear strobe;
- status that stays frozen while reporting is off.

Only the bench scenarios can show the matrix itself: the 8'hC1 column for bit 0, the stated row 0 membership, and zero-extension of narrow writes. Those scenarios also cover which bit gets flipped, first-error retention in the logs, and a clear losing to a simultaneous new error.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
   localparam int DW = 64;
   localparam int CW = 8;
   localparam logic [DW-1:0] ROW0_MASK = 64'h4DFF0F00_E2111111;
   localparam logic [CW-1:0] COL0_CODE = 8'hC1;

   typedef logic [DW-1:0][CW-1:0] hcol_t;
   typedef enum logic [1:0] {CLS_NONE, CLS_SBE_DATA, CLS_SBE_CHK, CLS_MBE} ecc_cls_e;

   function automatic bit code_ok(input logic [7:0] v);
      int w;
      w = 0;
      for (int b = 0; b < 8; b++) w += int'(v[b]);
      return (w % 2 == 1) && (w >= 3);
   endfunction

   function automatic hcol_t build_cols();
      hcol_t h;
      int    nxt1;
      int    nxt0;
      int    v;
      bit    want;
      h    = '0;
      nxt1 = 1;
      nxt0 = 1;
      h[0] = COL0_CODE;
      for (int i = 1; i < DW; i++) begin
         want = ROW0_MASK[i];
         v    = want ? nxt1 : nxt0;
         while (v < 256 && !(code_ok(v[7:0]) && (v[0] == want) && (v[7:0] != COL0_CODE))) v++;
         h[i] = v[7:0];
         if (want) nxt1 = v + 1;
         else      nxt0 = v + 1;
      end
      return h;
   endfunction

   function automatic logic [DW-1:0] row_mask(input hcol_t h, input int r);
      logic [DW-1:0] m;
      for (int i = 0; i < DW; i++) m[i] = h[i][r];
      return m;
   endfunction
endpackage

// File: rtl/ecc_chk_gen.sv
module ecc_chk_gen #(
   parameter int DATA_W  = 64,
   parameter int CHK_W   = 8,
   parameter bit ZEXT_EN = 1'b1
) (
   input  logic [DATA_W-1:0] data,
   input  logic              narrow,
   output logic [CHK_W-1:0]  check
);
   localparam int HALF = DATA_W / 2;
   localparam ecc_pkg::hcol_t H = ecc_pkg::build_cols();

   logic [DATA_W-1:0] dext;

   generate
      if (ZEXT_EN) begin : g_zext
         assign dext = narrow ? {{HALF{1'b0}}, data[HALF-1:0]} : data;
      end else begin : g_full
         assign dext = data;
      end
   endgenerate

   for (genvar r = 0; r < CHK_W; r++) begin : g_row
      assign check[r] = ^(dext & ecc_pkg::row_mask(H, r));
   end
endmodule

// File: rtl/ecc_syn_dec.sv
module ecc_syn_dec #(
   parameter int DATA_W = 64,
   parameter int CHK_W  = 8
) (
   input  logic [DATA_W-1:0]   data,
   input  logic [CHK_W-1:0]    check,
   input  logic                corr_en,
   output logic [CHK_W-1:0]    syn,
   output ecc_pkg::ecc_cls_e   cls,
   output logic [DATA_W-1:0]   fixed
);
   localparam ecc_pkg::hcol_t H = ecc_pkg::build_cols();

   logic [CHK_W-1:0]  regen;
   logic [DATA_W-1:0] hit;

   ecc_chk_gen #(.DATA_W(DATA_W), .CHK_W(CHK_W), .ZEXT_EN(1'b0)) u_regen (
      .data   (data),
      .narrow (1'b0),
      .check  (regen)
   );

   assign syn = regen ^ check;

   for (genvar g = 0; g < DATA_W; g++) begin : g_col
      assign hit[g] = (syn == H[g]);
   end

   always_comb begin
      if (syn == '0)                  cls = ecc_pkg::CLS_NONE;
      else if (|hit)                  cls = ecc_pkg::CLS_SBE_DATA;
      else if ($countones(syn) == 1)  cls = ecc_pkg::CLS_SBE_CHK;
      else                            cls = ecc_pkg::CLS_MBE;
   end

   assign fixed = (corr_en && cls == ecc_pkg::CLS_SBE_DATA) ? (data ^ hit) : data;
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log #(
   parameter int ADDR_W     = 32,
   parameter int CHK_W      = 8,
   parameter bit HOLD_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rpt_en,
   input  logic              ev_valid,
   input  logic              ev_sbe,
   input  logic              ev_mbe,
   input  logic              ev_posted,
   input  logic [ADDR_W-1:0] ev_addr,
   input  logic [CHK_W-1:0]  ev_syn,
   input  logic [2:0]        sts_clr,
   output logic [2:0]        sts,
   output logic              irq,
   output logic [ADDR_W-1:0] log_addr,
   output logic [CHK_W-1:0]  log_syn
);
   logic [2:0] set_v;
   logic       cap_ok;
   logic       cap;

   generate
      if (HOLD_FIRST) begin : g_first
         assign cap_ok = (sts[1:0] == 2'b00);
      end else begin : g_latest
         assign cap_ok = 1'b1;
      end
   endgenerate

   assign set_v[0] = rpt_en && ev_valid && ev_sbe;
   assign set_v[1] = rpt_en && ev_valid && ev_mbe && !ev_posted;
   assign set_v[2] = rpt_en && ev_valid && ev_mbe && ev_posted;
   assign cap      = (set_v[0] || set_v[1]) && cap_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sts      <= '0;
         log_addr <= '0;
         log_syn  <= '0;
      end else begin
         sts <= (sts & ~sts_clr) | set_v;
         if (cap) begin
            log_addr <= ev_addr;
            log_syn  <= ev_syn;
         end
      end
   end

   assign irq = |sts;

   AST_STICKY_SBE: assert property (@(posedge clk) disable iff (!rst_n)
      (sts[0] && !sts_clr[0]) |=> sts[0]);                                 // R9
   AST_IRQ_NEEDS_RPT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(rpt_en));                                        // R9
   AST_FALL_BY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sts[1]) |-> $past(sts_clr[1]));                                 // R10
   AST_QUIET_NO_RPT: assert property (@(posedge clk) disable iff (!rst_n)
      (!rpt_en && sts_clr == 3'b000) |=> ($stable(sts) && $stable(log_addr) && $stable(log_syn))); // R11
endmodule

// File: rtl/ecc_check_unit.sv
module ecc_check_unit #(
   parameter int DATA_W     = 64,
   parameter int CHK_W      = 8,
   parameter int ADDR_W     = 32,
   parameter bit ZEXT_EN    = 1'b1,
   parameter bit HOLD_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              corr_en,
   input  logic              rpt_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_narrow,
   output logic [CHK_W-1:0]  wr_check,
   input  logic              rd_valid,
   input  logic              rd_posted,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] rd_data,
   input  logic [CHK_W-1:0]  rd_check,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              out_abort,
   output logic              out_sbe,
   output logic              out_mbe,
   input  logic [2:0]        sts_clr,
   output logic [2:0]        sts,
   output logic              irq,
   output logic [ADDR_W-1:0] log_addr,
   output logic [CHK_W-1:0]  log_syn
);
   generate
      if (DATA_W != ecc_pkg::DW || CHK_W != ecc_pkg::CW) begin : g_bad_cfg
         $error("ecc_check_unit: matrix is fixed at 64 data and 8 check bits");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("ecc_check_unit: ADDR_W must be positive");
      end
   endgenerate

   logic [CHK_W-1:0]   syn;
   ecc_pkg::ecc_cls_e  cls;
   logic [DATA_W-1:0]  fixed;
   logic               is_sbe;
   logic               is_mbe;
   logic               do_abort;

   ecc_chk_gen #(.DATA_W(DATA_W), .CHK_W(CHK_W), .ZEXT_EN(ZEXT_EN)) u_wgen (
      .data   (wr_data),
      .narrow (wr_narrow),
      .check  (wr_check)
   );

   ecc_syn_dec #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_dec (
      .data    (rd_data),
      .check   (rd_check),
      .corr_en (corr_en),
      .syn     (syn),
      .cls     (cls),
      .fixed   (fixed)
   );

   assign is_sbe   = (cls == ecc_pkg::CLS_SBE_DATA) || (cls == ecc_pkg::CLS_SBE_CHK);
   assign is_mbe   = (cls == ecc_pkg::CLS_MBE);
   assign do_abort = is_mbe && !rd_posted;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_abort <= 1'b0;
         out_sbe   <= 1'b0;
         out_mbe   <= 1'b0;
      end else begin
         out_valid <= rd_valid;
         out_abort <= rd_valid && do_abort;
         out_sbe   <= rd_valid && is_sbe;
         out_mbe   <= rd_valid && is_mbe;
         if (rd_valid) out_data <= do_abort ? '0 : fixed;
      end
   end

   ecc_err_log #(.ADDR_W(ADDR_W), .CHK_W(CHK_W), .HOLD_FIRST(HOLD_FIRST)) u_log (
      .clk       (clk),
      .rst_n     (rst_n),
      .rpt_en    (rpt_en),
      .ev_valid  (rd_valid),
      .ev_sbe    (is_sbe),
      .ev_mbe    (is_mbe),
      .ev_posted (rd_posted),
      .ev_addr   (rd_addr),
      .ev_syn    (syn),
      .sts_clr   (sts_clr),
      .sts       (sts),
      .irq       (irq),
      .log_addr  (log_addr),
      .log_syn   (log_syn)
   );

   AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(rd_valid));                                         // R8
   AST_ABORT_NEEDS_MBE: assert property (@(posedge clk) disable iff (!rst_n)
      out_abort |-> (out_mbe && out_data == '0));                            // R6
   AST_POSTED_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(rd_posted)) |-> !out_abort);                       // R7
   AST_CLEAN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_sbe && !out_mbe) |-> (out_data == $past(rd_data))); // R2
   AST_NO_CORR_RAW: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rd_valid && !corr_en) && !out_mbe) |-> (out_data == $past(rd_data))); // R4
endmodule

// File: tb/sim_ecc_check_unit.sv
module sim_ecc_check_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        corr_en = 1'b0, rpt_en = 1'b0;
   logic [63:0] wr_data = '0;
   logic        wr_narrow = 1'b0;
   logic [7:0]  wr_check;
   logic        rd_valid = 1'b0, rd_posted = 1'b0;
   logic [31:0] rd_addr = '0;
   logic [63:0] rd_data = '0;
   logic [7:0]  rd_check = '0;
   logic        out_valid, out_abort, out_sbe, out_mbe, irq;
   logic [63:0] out_data;
   logic [2:0]  sts_clr = '0;
   logic [2:0]  sts;
   logic [31:0] log_addr;
   logic [7:0]  log_syn;

   always #2 clk = ~clk;

   ecc_check_unit u0 (
      .clk(clk), .rst_n(rst_n), .corr_en(corr_en), .rpt_en(rpt_en),
      .wr_data(wr_data), .wr_narrow(wr_narrow), .wr_check(wr_check),
      .rd_valid(rd_valid), .rd_posted(rd_posted), .rd_addr(rd_addr),
      .rd_data(rd_data), .rd_check(rd_check),
      .out_valid(out_valid), .out_data(out_data), .out_abort(out_abort),
      .out_sbe(out_sbe), .out_mbe(out_mbe),
      .sts_clr(sts_clr), .sts(sts), .irq(irq),
      .log_addr(log_addr), .log_syn(log_syn)
   );

   int n_cmp = 0, n_bad = 0;
   bit done = 0;
   logic [7:0]  bh [64];
   logic [2:0]  m_sts = '0;
   logic [31:0] m_addr = '0;
   logic [7:0]  m_syn = '0;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic int wgt(input logic [7:0] v);
      int w = 0;
      for (int b = 0; b < 8; b++) if (v[b]) w++;
      return w;
   endfunction

   task automatic build_h();
      logic [7:0] odd1 [$];
      logic [7:0] odd0 [$];
      logic [63:0] cls = 64'h4DFF0F00_E2111111;
      for (int v = 3; v < 256; v++) begin
         if (wgt(v[7:0]) >= 3 && wgt(v[7:0]) % 2 == 1 && v != 8'hC1) begin
            if (v[0]) odd1.push_back(v[7:0]);
            else      odd0.push_back(v[7:0]);
         end
      end
      bh[0] = 8'hC1;
      for (int i = 1; i < 64; i++) bh[i] = cls[i] ? odd1.pop_front() : odd0.pop_front();
   endtask

   function automatic logic [7:0] b_gen(input logic [63:0] d);
      logic [7:0] c = '0;
      for (int i = 0; i < 64; i++) if (d[i]) c ^= bh[i];
      return c;
   endfunction

   task automatic run_read(input logic [31:0] a, input logic [63:0] d, input logic [7:0] c,
                           input bit post, input string tag);
      logic [7:0]  s;
      int          idx;
      bit          sbe, mbe, cap;
      logic [63:0] ed;
      logic [2:0]  setv;
      s = b_gen(d) ^ c;
      idx = -1;
      for (int i = 0; i < 64; i++) if (bh[i] == s && s != 0) idx = i;
      sbe = (idx >= 0) || (wgt(s) == 1);
      mbe = (s != 0) && !sbe;
      ed  = (mbe && !post) ? 64'd0 : ((idx >= 0 && corr_en) ? d ^ (64'd1 << idx) : d);
      setv = {rpt_en && mbe && post, rpt_en && mbe && !post, rpt_en && sbe};
      cap  = (setv[0] || setv[1]) && (m_sts[1:0] == 2'b00);
      if (cap) begin m_addr = a; m_syn = s; end
      m_sts = (m_sts & ~sts_clr) | setv;
      rd_valid = 1; rd_addr = a; rd_data = d; rd_check = c; rd_posted = post;
      @(posedge clk); @(negedge clk);
      rd_valid = 0; sts_clr = '0;
      chk(out_valid == 1'b1, {tag, " R8 valid"}, out_valid, 1);
      chk(out_data == ed, {tag, " data"}, out_data, ed);
      chk(out_sbe == sbe, {tag, " sbe"}, out_sbe, sbe);
      chk(out_mbe == mbe, {tag, " R6 mbe"}, out_mbe, mbe);
      chk(out_abort == (mbe && !post), {tag, " R7 abort"}, out_abort, mbe && !post);
      chk(sts == m_sts, {tag, " R9 sts"}, sts, m_sts);
      chk(irq == (m_sts != 0), {tag, " R9 irq"}, irq, m_sts != 0);
      chk(log_addr == m_addr, {tag, " R9 log_addr"}, log_addr, m_addr);
      chk(log_syn == m_syn, {tag, " R1 log_syn"}, log_syn, m_syn);
   endtask

   task automatic clear_all();
      sts_clr = 3'b111;
      @(negedge clk);
      sts_clr = '0;
      m_sts = '0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [63:0] d;
      logic [7:0]  c;
      void'($urandom(32'd4242));
      build_h();
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R8: reset state
      chk(out_valid == 0 && sts == 0 && irq == 0, "R8 reset flags", {out_valid, sts, irq}, 0);
      chk(log_addr == 0 && log_syn == 0, "R8 reset logs", {log_addr, log_syn}, 0);

      // R1: stated row 0 membership and column 0
      wr_data = 64'd1 << 25; #1;
      chk(wr_check[0] == 1'b1, "R1 bit25 in row0", wr_check, 1);
      wr_data = 64'd1 << 1; #1;
      chk(wr_check[0] == 1'b0, "R1 bit1 not in row0", wr_check, 0);
      wr_data = 64'd1; #1;
      chk(wr_check == 8'hC1, "R1 column0", wr_check, 8'hC1);
      // R12: full and narrow generation
      for (int k = 0; k < 20; k++) begin
         wr_data = {$urandom, $urandom};
         wr_narrow = k[0];
         #1;
         chk(wr_check == b_gen(k[0] ? {32'd0, wr_data[31:0]} : wr_data), "R12 wr_check",
             wr_check, b_gen(k[0] ? {32'd0, wr_data[31:0]} : wr_data));
      end
      wr_narrow = 0;
      @(negedge clk);

      rpt_en = 1; corr_en = 1;
      d = 64'h0123_4567_89AB_CDEF; c = b_gen(d);
      run_read(32'h100, d, c, 0, "R2 clean");
      run_read(32'h200, d ^ 64'd1, c, 0, "R3 bit0 fix");
      chk(log_syn == 8'hC1, "R1 R3 syndrome bit0", log_syn, 8'hC1);
      run_read(32'h300, d ^ (64'd1 << 40), c, 0, "R9 first kept");
      chk(log_addr == 32'h200, "R9 hold first", log_addr, 32'h200);
      // R10: set wins over simultaneous clear
      sts_clr = 3'b001;
      run_read(32'h340, d ^ (64'd1 << 7), c, 0, "R10 set wins");
      chk(sts[0] == 1'b1, "R10 set over clear", sts, 1);
      sts_clr = 3'b001; @(negedge clk); sts_clr = 0; m_sts[0] = 0;
      chk(sts == 3'b000 && irq == 0, "R10 w1c", {sts, irq}, 0);
      corr_en = 0;
      run_read(32'h400, d ^ (64'd1 << 63), c, 0, "R4 no corr");
      clear_all(); corr_en = 1;
      run_read(32'h500, d, c ^ 8'h10, 0, "R5 check bit");
      clear_all();
      run_read(32'h600, d ^ 64'h3, c, 0, "R6 double");
      clear_all();
      run_read(32'h700, d ^ 64'h30, c, 1, "R7 posted");
      chk(sts == 3'b100 && log_addr == 32'h600, "R7 only sts2", {sts, log_addr}, {3'b100, 32'h600});
      clear_all();
      rpt_en = 0;
      run_read(32'h800, d ^ 64'h5, c, 0, "R11 rpt off");
      run_read(32'h900, d ^ 64'h4, c, 0, "R11 rpt off sbe");
      chk(sts == 0 && log_addr == 32'h600, "R11 untouched", {sts, log_addr}, {3'b0, 32'h600});
      // R8: one-cycle pulse
      @(negedge clk);
      chk(out_valid == 0, "R8 valid drops", out_valid, 0);

      // random mix
      for (int n = 0; n < 400; n++) begin
         int nfl, p1, p2;
         logic [71:0] cw;
         d = {$urandom, $urandom};
         cw = {b_gen(d), d};
         nfl = $urandom % 3;
         p1 = $urandom % 72;
         p2 = (p1 + 1 + ($urandom % 71)) % 72;
         if (nfl >= 1) cw[p1] = ~cw[p1];
         if (nfl == 2) cw[p2] = ~cw[p2];
         corr_en = $urandom % 2;
         rpt_en  = ($urandom % 4) != 0;
         if ($urandom % 3 == 0) sts_clr = $urandom % 8;
         run_read($urandom, cw[63:0], cw[71:64], ($urandom % 4) == 0, "R2 R3 R5 R6 rand");
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule